// File: doc/BRIEF.md
# Reorder Buffer with Paced Squash

The block is a circular queue that keeps in-flight instructions in program order. Each slot holds a sequence number, a program counter, a successor program counter, a completion bit and a squash bit. A producer appends one instruction per cycle at the tail. An execution side marks a slot complete by its slot index, which the block announces at insert time. A commit side retires the oldest entry once it has completed.

A squash request carries a sequence number. The block keeps every entry whose number is less than or equal to it and discards every entry with a larger number. The discard happens in two phases. First, a walker starts at the youngest entry and moves toward the head, marking at most `SQ_W` entries per cycle. The tail pointer and the occupancy count do not move during this phase. Second, once the walk has ended, the marked entries are removed from the tail, one per cycle. A done flag stays low for the whole marking phase.

Top module: `reorder_buf`

## Requirements
- R1: `full_o` is high exactly when `count_o` equals `DEPTH`, `empty_o` is high exactly when `count_o` is zero, and `free_o` equals `DEPTH - count_o`.
- R2: An insert is accepted when `ins_valid_i` is high, no walk is active, no squash is accepted in the same cycle, and the tail entry is not waiting to be reclaimed. The new entry is written into slot `ins_slot_o`. From the next cycle it appears on `tail_seq_o` and `tail_pc_o`, and the count rises by one.
- R3: The producer must not raise `ins_valid_i` while `full_o` is high and `sq_done_o` is high. Overflow is not guarded beyond the checker.
- R4: `cmpl_valid_i` sets the completion bit of slot `cmpl_slot_i`. `head_ready_o` is high when the buffer is non-empty and the head entry is complete and not squashed.
- R5: `retire_i` removes the head only when `head_ready_o` is high, no walk is active and no squash is accepted in that cycle; otherwise it is ignored. An accepted insert and an accepted retire in the same cycle leave the count unchanged.
- R6: After a squash, the buffer keeps exactly the entries whose sequence number, compared unsigned, is less than or equal to the request number. The entry holding the request number is kept.
- R7: `sq_done_o` falls in the cycle after a squash is accepted on a non-empty buffer. It stays low for ceil(min(count, younger + 1) / `SQ_W`) cycles, where younger is the number of entries to be discarded, and then rises.
- R8: While `sq_done_o` is low, `count_o` and the tail outputs hold their values, and inserts and retires are ignored.
- R9: After the walk ends, squashed entries leave from the tail one per cycle, and `count_o` falls by one each cycle until the youngest kept entry is the tail.
- R10: A squash request is ignored while the buffer is empty, while a walk is active, or while squashed entries remain. On an empty buffer, `sq_done_o` stays high.
- R11: After reset the buffer is empty: count zero, `free_o` equal to `DEPTH`, `sq_done_o` high and `head_ready_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Insert request |
| ins_seq_i | input | SEQ_W | Sequence number of the inserted instruction |
| ins_pc_i | input | PC_W | Program counter of the inserted instruction |
| ins_npc_i | input | PC_W | Successor program counter of the inserted instruction |
| ins_slot_o | output | PTR_W | Slot that the next insert will occupy |
| cmpl_valid_i | input | 1 | Completion strobe |
| cmpl_slot_i | input | PTR_W | Slot to mark complete |
| retire_i | input | 1 | Retire request for the head entry |
| sq_req_i | input | 1 | Squash request |
| sq_seq_i | input | SEQ_W | Sequence number of the squash request; younger entries are discarded |
| head_ready_o | output | 1 | Head entry is complete and not squashed |
| head_seq_o | output | SEQ_W | Head sequence number (undefined when empty) |
| head_pc_o | output | PC_W | Head program counter (undefined when empty) |
| head_npc_o | output | PC_W | Head successor program counter (undefined when empty) |
| tail_seq_o | output | SEQ_W | Sequence number of the youngest entry |
| tail_pc_o | output | PC_W | Program counter of the youngest entry |
| count_o | output | CNT_W | Occupied entries |
| free_o | output | CNT_W | Free entries |
| full_o | output | 1 | Buffer full |
| empty_o | output | 1 | Buffer empty |
| sq_done_o | output | 1 | No squash walk is in progress |

## Verification
Two pairs of functions can fall in the same cycle.

Insert and retire: the bench raises both while the head is ready and expects the count to stay the same, the head to advance and the tail to show the new entry.

Squash and the other two: the bench keeps `ins_valid_i`, `retire_i` and a second squash request high for the whole marking phase. It counts the cycles with `sq_done_o` low against the figure R7 gives, and checks that the count, head and tail did not move. It then checks that the final contents match the first request only.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_RUN  = 1'b1
  } wk_state_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTR_W = 3,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_head_i,
  input  logic             pop_tail_i,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [CNT_W-1:0] count_o
);
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (pop_head_i) rd_q <= rd_q + PTR_W'(1);
      // push and tail pop never coincide
      if (push_i)          wr_q <= wr_q + PTR_W'(1);
      else if (pop_tail_i) wr_q <= wr_q - PTR_W'(1);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_head_i) - CNT_W'(pop_tail_i);
    end
  end

  assign rd_ptr_o = rd_q;
  assign wr_ptr_o = wr_q;
  assign count_o  = cnt_q;
endmodule

// File: rtl/rob_store.sv
module rob_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTR_W = 3,
  parameter int unsigned SEQ_W = 16,
  parameter int unsigned PC_W  = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [PTR_W-1:0]            wr_idx_i,
  input  logic [SEQ_W-1:0]            wr_seq_i,
  input  logic [PC_W-1:0]             wr_pc_i,
  input  logic [PC_W-1:0]             wr_npc_i,
  input  logic                        cmpl_en_i,
  input  logic [PTR_W-1:0]            cmpl_idx_i,
  input  logic [DEPTH-1:0]            mark_i,
  output logic [DEPTH-1:0][SEQ_W-1:0] seq_all_o,
  output logic [DEPTH-1:0][PC_W-1:0]  pc_all_o,
  output logic [DEPTH-1:0][PC_W-1:0]  npc_all_o,
  output logic [DEPTH-1:0]            done_o,
  output logic [DEPTH-1:0]            sqd_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit_wr, hit_cm;
    assign hit_wr = wr_en_i && (wr_idx_i == PTR_W'(g));
    assign hit_cm = cmpl_en_i && (cmpl_idx_i == PTR_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        seq_all_o[g] <= '0;
        pc_all_o[g]  <= '0;
        npc_all_o[g] <= '0;
        done_o[g]    <= 1'b0;
        sqd_o[g]     <= 1'b0;
      end else if (hit_wr) begin
        seq_all_o[g] <= wr_seq_i;
        pc_all_o[g]  <= wr_pc_i;
        npc_all_o[g] <= wr_npc_i;
        done_o[g]    <= 1'b0;
        sqd_o[g]     <= 1'b0;
      end else begin
        if (hit_cm)    done_o[g] <= 1'b1;
        if (mark_i[g]) sqd_o[g]  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rob_walk.sv
module rob_walk
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SQ_W  = 2,
  parameter int unsigned PTR_W = 3,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned SEQ_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [SEQ_W-1:0]            start_seq_i,
  input  logic [PTR_W-1:0]            tail_idx_i,
  input  logic [CNT_W-1:0]            count_i,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq_all_i,
  output logic                        busy_o,
  output logic [DEPTH-1:0]            mark_o
);
  wk_state_e        st_q;
  logic [PTR_W-1:0] ptr_q;   // parked at zero when idle
  logic [CNT_W-1:0] left_q;
  logic [SEQ_W-1:0] seq_q;
  logic             stop, last;
  logic [PTR_W-1:0] idx;

  always_comb begin
    mark_o = '0;
    stop   = 1'b0;
    idx    = ptr_q;
    for (int k = 0; k < SQ_W; k++) begin
      idx = ptr_q - PTR_W'(k);
      if (st_q == WK_RUN && !stop && CNT_W'(k) < left_q) begin
        if (seq_all_i[idx] > seq_q) mark_o[idx] = 1'b1;
        else                        stop        = 1'b1;
      end
    end
    last = stop || (left_q <= CNT_W'(SQ_W));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= WK_IDLE;
      ptr_q  <= '0;
      left_q <= '0;
      seq_q  <= '0;
    end else begin
      unique case (st_q)
        WK_IDLE: if (start_i && count_i != '0) begin
          st_q   <= WK_RUN;
          ptr_q  <= tail_idx_i;
          left_q <= count_i;
          seq_q  <= start_seq_i;
        end
        WK_RUN: if (last) begin
          st_q   <= WK_IDLE;
          ptr_q  <= '0;
          left_q <= '0;
        end else begin
          ptr_q  <= ptr_q - PTR_W'(SQ_W);
          left_q <= left_q - CNT_W'(SQ_W);
        end
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q == WK_RUN);
endmodule

// File: rtl/reorder_buf.sv
module reorder_buf #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SQ_W  = 2,
  parameter int unsigned SEQ_W = 16,
  parameter int unsigned PC_W  = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ins_valid_i,
  input  logic [SEQ_W-1:0] ins_seq_i,
  input  logic [PC_W-1:0]  ins_pc_i,
  input  logic [PC_W-1:0]  ins_npc_i,
  output logic [PTR_W-1:0] ins_slot_o,
  input  logic             cmpl_valid_i,
  input  logic [PTR_W-1:0] cmpl_slot_i,
  input  logic             retire_i,
  input  logic             sq_req_i,
  input  logic [SEQ_W-1:0] sq_seq_i,
  output logic             head_ready_o,
  output logic [SEQ_W-1:0] head_seq_o,
  output logic [PC_W-1:0]  head_pc_o,
  output logic [PC_W-1:0]  head_npc_o,
  output logic [SEQ_W-1:0] tail_seq_o,
  output logic [PC_W-1:0]  tail_pc_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] free_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             sq_done_o
);
  logic [PTR_W-1:0]            rd_ptr, wr_ptr, tail_idx;
  logic [CNT_W-1:0]            cnt;
  logic [DEPTH-1:0][SEQ_W-1:0] seq_all;
  logic [DEPTH-1:0][PC_W-1:0]  pc_all, npc_all;
  logic [DEPTH-1:0]            done_v, sqd_v, mark_v;
  logic                        walk_busy, is_empty, rec_pend;
  logic                        sq_acc, ins_acc, ret_acc, hd_rdy;

  assign tail_idx = wr_ptr - PTR_W'(1);
  assign is_empty = (cnt == '0);
  assign rec_pend = !is_empty && !walk_busy && sqd_v[tail_idx];
  assign sq_acc   = sq_req_i && !walk_busy && !rec_pend && !is_empty;
  assign ins_acc  = ins_valid_i && !walk_busy && !rec_pend && !sq_acc;
  assign hd_rdy   = !is_empty && done_v[rd_ptr] && !sqd_v[rd_ptr];
  assign ret_acc  = retire_i && hd_rdy && !walk_busy && !sq_acc;

  rob_ptrs #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptrs (
    .clk_i, .rst_ni,
    .push_i    (ins_acc),
    .pop_head_i(ret_acc),
    .pop_tail_i(rec_pend),
    .rd_ptr_o  (rd_ptr),
    .wr_ptr_o  (wr_ptr),
    .count_o   (cnt)
  );

  rob_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .SEQ_W(SEQ_W), .PC_W(PC_W)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i   (ins_acc),
    .wr_idx_i  (wr_ptr),
    .wr_seq_i  (ins_seq_i),
    .wr_pc_i   (ins_pc_i),
    .wr_npc_i  (ins_npc_i),
    .cmpl_en_i (cmpl_valid_i),
    .cmpl_idx_i(cmpl_slot_i),
    .mark_i    (mark_v),
    .seq_all_o (seq_all),
    .pc_all_o  (pc_all),
    .npc_all_o (npc_all),
    .done_o    (done_v),
    .sqd_o     (sqd_v)
  );

  rob_walk #(.DEPTH(DEPTH), .SQ_W(SQ_W), .PTR_W(PTR_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_walk (
    .clk_i, .rst_ni,
    .start_i    (sq_acc),
    .start_seq_i(sq_seq_i),
    .tail_idx_i (tail_idx),
    .count_i    (cnt),
    .seq_all_i  (seq_all),
    .busy_o     (walk_busy),
    .mark_o     (mark_v)
  );

  assign ins_slot_o   = wr_ptr;
  assign head_ready_o = hd_rdy;
  assign head_seq_o   = seq_all[rd_ptr];
  assign head_pc_o    = pc_all[rd_ptr];
  assign head_npc_o   = npc_all[rd_ptr];
  assign tail_seq_o   = seq_all[tail_idx];
  assign tail_pc_o    = pc_all[tail_idx];
  assign count_o      = cnt;
  assign free_o       = CNT_W'(DEPTH) - cnt;
  assign full_o       = (cnt == CNT_W'(DEPTH));
  assign empty_o      = is_empty;
  assign sq_done_o    = !walk_busy;
endmodule

// File: rtl/reorder_buf_sva.sv
module reorder_buf_sva #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SEQ_W = 16,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ins_valid_i,
  input logic             sq_req_i,
  input logic             full_o,
  input logic             empty_o,
  input logic             sq_done_o,
  input logic [CNT_W-1:0] count_o,
  input logic [SEQ_W-1:0] tail_seq_o
);
  AST_COUNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && sq_done_o |-> !ins_valid_i); // R3
  AST_WALK_COUNT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sq_done_o |=> $stable(count_o)); // R8
  AST_WALK_TAIL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sq_done_o |=> $stable(tail_seq_o)); // R8
  AST_DONE_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sq_done_o) |-> $past(sq_req_i)); // R7
  AST_EMPTY_NO_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && sq_done_o |=> sq_done_o); // R10
endmodule

bind reorder_buf reorder_buf_sva #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ins_valid_i(ins_valid_i),
  .sq_req_i   (sq_req_i),
  .full_o     (full_o),
  .empty_o    (empty_o),
  .sq_done_o  (sq_done_o),
  .count_o    (count_o),
  .tail_seq_o (tail_seq_o)
);

// File: tb/sim_reorder_buf.sv
module sim_reorder_buf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int SQ_W  = 2;
  localparam int SEQ_W = 16;
  localparam int PC_W  = 32;
  localparam int PTR_W = 3;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0, cmpl_valid = 1'b0, retire = 1'b0, sq_req = 1'b0;
  logic [SEQ_W-1:0] ins_seq = '0, sq_seq = '0;
  logic [PC_W-1:0]  ins_pc = '0, ins_npc = '0;
  logic [PTR_W-1:0] cmpl_slot = '0;
  logic [PTR_W-1:0] ins_slot;
  logic head_ready, full, empty, sq_done;
  logic [SEQ_W-1:0] head_seq, tail_seq;
  logic [PC_W-1:0]  head_pc, head_npc, tail_pc;
  logic [CNT_W-1:0] count, free;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reorder_buf #(.DEPTH(DEPTH), .SQ_W(SQ_W), .SEQ_W(SEQ_W), .PC_W(PC_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ins_valid_i(ins_valid), .ins_seq_i(ins_seq), .ins_pc_i(ins_pc), .ins_npc_i(ins_npc),
    .ins_slot_o(ins_slot),
    .cmpl_valid_i(cmpl_valid), .cmpl_slot_i(cmpl_slot),
    .retire_i(retire), .sq_req_i(sq_req), .sq_seq_i(sq_seq),
    .head_ready_o(head_ready), .head_seq_o(head_seq), .head_pc_o(head_pc), .head_npc_o(head_npc),
    .tail_seq_o(tail_seq), .tail_pc_o(tail_pc),
    .count_o(count), .free_o(free), .full_o(full), .empty_o(empty), .sq_done_o(sq_done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input int s);
    ins_valid = 1'b1;
    ins_seq   = SEQ_W'(s);
    ins_pc    = PC_W'(s * 4);
    ins_npc   = PC_W'(s * 4 + 4);
    tick();
    ins_valid = 1'b0;
  endtask

  task automatic complete(input int slot);
    cmpl_valid = 1'b1;
    cmpl_slot  = PTR_W'(slot);
    tick();
    cmpl_valid = 1'b0;
  endtask

  // request a squash, return number of cycles sq_done stays low
  task automatic squash(input int s, input logic disturb, input int exp_cnt, output int low);
    sq_req = 1'b1;
    sq_seq = SEQ_W'(s);
    tick();
    sq_req = 1'b0;
    if (disturb) begin
      ins_valid = 1'b1; ins_seq = 16'd99; ins_pc = 32'd396; ins_npc = 32'd400;
      retire = 1'b1; sq_req = 1'b1; sq_seq = 16'd12;
    end
    low = 0;
    while (!sq_done && low < 20) begin
      low++;
      chk("R8 count held during walk", count, exp_cnt);
      tick();
    end
    ins_valid = 1'b0; retire = 1'b0; sq_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 count", count, 0);
    chk("R11 empty", empty, 1);
    chk("R11 free", free, DEPTH);
    chk("R11 done", sq_done, 1);
    chk("R11 head_ready", head_ready, 0);
  endtask

  task automatic t_fill();
    for (int s = 10; s < 18; s++) begin
      chk("R2 slot", ins_slot, (s - 10) % DEPTH);
      put(s);
    end
    chk("R1 count full", count, 8);
    chk("R1 full", full, 1);
    chk("R1 free", free, 0);
    chk("R1 empty", empty, 0);
    chk("R2 tail_seq", tail_seq, 17);
    chk("R2 tail_pc", tail_pc, 68);
    chk("R2 head_seq", head_seq, 10);
    chk("R2 head_pc", head_pc, 40);
    chk("R2 head_npc", head_npc, 44);
  endtask

  task automatic t_retire();
    retire = 1'b1; tick(); retire = 1'b0;
    chk("R5 retire ignored when not ready", count, 8);
    chk("R4 head not ready", head_ready, 0);
    complete(0);
    chk("R4 head ready", head_ready, 1);
    retire = 1'b1; tick(); retire = 1'b0;
    chk("R5 retire count", count, 7);
    chk("R5 retire head", head_seq, 11);
    complete(1);
    complete(2);
    retire = 1'b1;
    put(18);
    retire = 1'b0;
    chk("R5 insert+retire count", count, 7);
    chk("R5 insert+retire head", head_seq, 12);
    chk("R2 insert+retire tail", tail_seq, 18);
  endtask

  task automatic t_squash_partial();
    int low;
    squash(14, 1'b1, 7, low);
    chk("R7 walk cycles", low, 3);
    chk("R8 tail held", tail_seq, 18);
    chk("R8 retire ignored", head_seq, 12);
    chk("R8 count after walk", count, 7);
    for (int e = 6; e >= 3; e--) begin
      tick();
      chk("R9 reclaim step", count, e);
    end
    tick();
    chk("R9 reclaim stops", count, 3);
    chk("R6 tail kept equal", tail_seq, 14);
    chk("R6 tail pc", tail_pc, 56);
    chk("R10 second request ignored head", head_seq, 12);
  endtask

  task automatic t_squash_all();
    int low;
    squash(5, 1'b0, 3, low);
    chk("R7 walk cycles all", low, 2);
    repeat (4) tick();
    chk("R9 all reclaimed count", count, 0);
    chk("R1 empty after squash", empty, 1);
    chk("R1 free after squash", free, DEPTH);
  endtask

  task automatic t_squash_empty();
    sq_req = 1'b1; sq_seq = 16'd0; tick(); sq_req = 1'b0;
    chk("R10 empty squash done", sq_done, 1);
    chk("R10 empty squash count", count, 0);
  endtask

  task automatic t_keep_equal();
    int low;
    put(20);
    put(21);
    squash(21, 1'b0, 2, low);
    chk("R7 walk cycles none", low, 1);
    repeat (2) tick();
    chk("R6 nothing squashed", count, 2);
    chk("R6 tail 21", tail_seq, 21);
    squash(20, 1'b0, 2, low);
    chk("R7 walk cycles one", low, 1);
    put(30);  // offered while tail entry awaits reclaim
    chk("R2 insert blocked by reclaim count", count, 1);
    chk("R2 insert blocked by reclaim tail", tail_seq, 20);
    tick();
    chk("R9 reclaim final", count, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_fill();
    t_retire();
    t_squash_partial();
    t_squash_all();
    t_squash_empty();
    t_keep_equal();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule